// File: doc/BRIEF.md
# NOR Flash Identification Query Sequencer

This block reads the identification words from a parallel NOR flash that uses the classic unlock-cycle command set. A start pulse makes it run a fixed program of single-cycle bus operations on a simple synchronous flash port. First it sends the reset command and records the array word at offset zero. Then it sends the three-write unlock sequence that switches the part into identification mode. Then it reads the vendor code and three device-ID words into four output registers.

After the reads, the block writes the reset command to offset zero. It then polls offset zero until the value read back equals the word it recorded at the start, which shows that the part is back in array-read mode. The poll has a bound: after `POLL_LIMIT` reads that do not match, the block gives up and reports a timeout together with its done pulse.

A parameter selects the address map. Word-wide parts use one map and byte-addressed parts use another, which changes both the unlock addresses and the ID offsets. Bus electrical timing and matching the ID words against a table of known parts are left to other logic.

Top module: `nor_id_probe`

## Requirements
- R1: After reset, `done`, `timed_out`, `flash_wr` and `flash_rd` are low, and all four ID outputs are all ones.
- R2: When `start` is seen while idle, the first bus operation is a write of 0xF0 to unlock address A. A is 0x555 in word map and 0xAAA in byte map. The next operation is a read of offset 0, and the block keeps that read value as the recorded word.
- R3: Next come three writes in this order: 0xAA to unlock address A, then 0x55 to unlock address B, then 0x90 to unlock address A. B is 0x2AA in word map and 0x555 in byte map.
- R4: Next come four reads whose data go, in order, to `id_vendor`, `id_dev1`, `id_dev2` and `id_dev3`. The offsets are 0, 0x01, 0x0E and 0x0F in word map, and 0, 0x02, 0x1C and 0x1E in byte map.
- R5: After the ID reads, the block writes 0xF0 to offset 0. It then repeatedly reads offset 0 and stops at the first read whose data equals the recorded word.
- R6: If `POLL_LIMIT` poll reads all fail to match, the block stops polling and ends with a timeout.
- R7: Each bus operation raises `flash_wr` or `flash_rd`, never both, for exactly one clock. The clock after any strobe has no strobe.
- R8: Read data is taken from `flash_rdata` in the clock that follows the read-strobe clock.
- R9: `done` is a one-clock pulse at the end of every sequence. `timed_out` is high only during that pulse and only when the poll did not match.
- R10: When a start is accepted, all four ID outputs return to all ones. Each one keeps that value until its own read.
- R11: A `start` raised while a sequence is running is ignored. No operation is added, the sequence is not restarted, and no extra `done` appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a query (taken only when idle) |
| done | output | 1 | One-clock end-of-sequence pulse |
| timed_out | output | 1 | High with `done` when the return poll expired |
| id_vendor | output | DATA_W | Vendor code |
| id_dev1 | output | DATA_W | First device-ID word |
| id_dev2 | output | DATA_W | Second device-ID word |
| id_dev3 | output | DATA_W | Third device-ID word |
| flash_addr | output | ADDR_W | Flash word/byte address |
| flash_wdata | output | DATA_W | Command data for writes |
| flash_wr | output | 1 | Write strobe, one clock per write |
| flash_rd | output | 1 | Read strobe, one clock per read |
| flash_rdata | input | DATA_W | Read data, valid the clock after `flash_rd` |

## Verification
The embedded properties check the bus-level rules on every clock:
- a strobe always lasts a single clock, and the two strobes are never high together;
- `done` is a pulse, and `timed_out` never appears without it;
- the poll counter stays below its limit;
- an accepted start resets the ID registers to all ones and leads straight to the reset-command write.

Other behaviour needs the bench's flash model:
- the exact order of addresses and command values in both maps;
- that the recorded word is what ends the poll;
- the exact poll count at the limit and one read short of it;
- that a start during a run is ignored.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

    localparam int OFFS_W = 12;
    localparam int CMD_W  = 8;
    localparam int N_IDS  = 4;

    localparam logic [CMD_W-1:0] CMD_RESET  = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_KEY1   = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_KEY2   = 8'h55;
    localparam logic [CMD_W-1:0] CMD_IDMODE = 8'h90;

    // Program order of the query; the order is the protocol.
    typedef enum logic [3:0] {
        ST_RST_CMD  = 4'd0,
        ST_HOLD_RD  = 4'd1,
        ST_KEY1_WR  = 4'd2,
        ST_KEY2_WR  = 4'd3,
        ST_IDM_WR   = 4'd4,
        ST_VEND_RD  = 4'd5,
        ST_DEV1_RD  = 4'd6,
        ST_DEV2_RD  = 4'd7,
        ST_DEV3_RD  = 4'd8,
        ST_EXIT_WR  = 4'd9,
        ST_POLL_RD  = 4'd10
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STROBE = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;

    typedef struct packed {
        logic              is_wr;
        logic [OFFS_W-1:0] offs;
        logic [CMD_W-1:0]  cmd;
    } bus_op_t;

    function automatic logic [OFFS_W-1:0] unlock_a(input logic byte_map);
        return byte_map ? 12'hAAA : 12'h555;
    endfunction

    function automatic logic [OFFS_W-1:0] unlock_b(input logic byte_map);
        return byte_map ? 12'h555 : 12'h2AA;
    endfunction

    // Word-map ID offsets; byte map doubles them.
    function automatic logic [OFFS_W-1:0] id_offs(input int slot, input logic byte_map);
        logic [OFFS_W-1:0] w;
        case (slot)
            0:       w = 12'h000;
            1:       w = 12'h001;
            2:       w = 12'h00E;
            default: w = 12'h00F;
        endcase
        return byte_map ? (w << 1) : w;
    endfunction

    function automatic step_e slot_step(input int slot);
        return step_e'(4'(int'(ST_VEND_RD) + slot));
    endfunction

    function automatic bus_op_t step_op(input step_e s, input logic byte_map);
        bus_op_t o;
        o = '0;
        case (s)
            ST_RST_CMD: begin o.is_wr = 1'b1; o.offs = unlock_a(byte_map); o.cmd = CMD_RESET;  end
            ST_HOLD_RD: begin o.is_wr = 1'b0; o.offs = '0; end
            ST_KEY1_WR: begin o.is_wr = 1'b1; o.offs = unlock_a(byte_map); o.cmd = CMD_KEY1;   end
            ST_KEY2_WR: begin o.is_wr = 1'b1; o.offs = unlock_b(byte_map); o.cmd = CMD_KEY2;   end
            ST_IDM_WR:  begin o.is_wr = 1'b1; o.offs = unlock_a(byte_map); o.cmd = CMD_IDMODE; end
            ST_VEND_RD: begin o.is_wr = 1'b0; o.offs = id_offs(0, byte_map); end
            ST_DEV1_RD: begin o.is_wr = 1'b0; o.offs = id_offs(1, byte_map); end
            ST_DEV2_RD: begin o.is_wr = 1'b0; o.offs = id_offs(2, byte_map); end
            ST_DEV3_RD: begin o.is_wr = 1'b0; o.offs = id_offs(3, byte_map); end
            ST_EXIT_WR: begin o.is_wr = 1'b1; o.offs = '0; o.cmd = CMD_RESET; end
            default:    begin o.is_wr = 1'b0; o.offs = '0; end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/nor_id_step_table.sv
module nor_id_step_table
    import nor_id_pkg::*;
#(
    parameter int BYTE_MAP = 0
) (
    input  step_e   step,
    output bus_op_t op
);
    localparam logic BM = (BYTE_MAP != 0);

    always_comb begin
        op = step_op(step, BM);
    end
endmodule

// File: rtl/nor_id_poll_ctr.sv
module nor_id_poll_ctr #(
    parameter int POLL_LIMIT = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(POLL_LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);

    // R6: poll count never passes its bound
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(POLL_LIMIT));
    // R6: the counter never advances past the last allowed read
    a_r6_no_inc_at_last: assert property (@(posedge clk) disable iff (rst)
        (last && !clr) |=> (cnt_q == LAST_VAL));
endmodule

// File: rtl/nor_id_capture.sv
module nor_id_capture
    import nor_id_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     preset,
    input  logic                     cap_en,
    input  step_e                    step,
    input  logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        hold_word,
    output logic [N_IDS-1:0][DATA_W-1:0] ids
);
    always_ff @(posedge clk) begin
        if (rst)                                hold_word <= '0;
        else if (cap_en && step == ST_HOLD_RD)  hold_word <= rdata;
    end

    for (genvar g = 0; g < N_IDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || preset)                           ids[g] <= '1;
            else if (cap_en && step == slot_step(g))     ids[g] <= rdata;
        end

        // R10: an accepted start leaves every ID register all ones
        a_r10_preset_ones: assert property (@(posedge clk) disable iff (rst)
            preset |=> (ids[g] == '1));
        // R10: a slot changes only on preset or its own read
        a_r10_slot_stable: assert property (@(posedge clk) disable iff (rst)
            (!preset && !(cap_en && step == slot_step(g))) |=> $stable(ids[g]));
    end
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
    import nor_id_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 500000,
    parameter int BYTE_MAP   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic              timed_out,
    output logic [DATA_W-1:0] id_vendor,
    output logic [DATA_W-1:0] id_dev1,
    output logic [DATA_W-1:0] id_dev2,
    output logic [DATA_W-1:0] id_dev3,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [DATA_W-1:0] flash_wdata,
    output logic              flash_wr,
    output logic              flash_rd,
    input  logic [DATA_W-1:0] flash_rdata
);
    phase_e  phase_q;
    step_e   step_q;
    logic    timed_q;
    bus_op_t op;

    logic accept, sample_now, poll_active, poll_match, poll_last, poll_inc;
    logic [DATA_W-1:0] hold_word;
    logic [N_IDS-1:0][DATA_W-1:0] ids;

    nor_id_step_table #(.BYTE_MAP(BYTE_MAP)) u_table (
        .step (step_q),
        .op   (op)
    );

    assign accept      = (phase_q == PH_IDLE) && start;
    assign sample_now  = (phase_q == PH_SAMPLE) && !op.is_wr;
    assign poll_active = (step_q == ST_POLL_RD);
    assign poll_match  = (flash_rdata == hold_word);
    assign poll_inc    = sample_now && poll_active && !poll_match && !poll_last;

    nor_id_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .inc  (poll_inc),
        .last (poll_last)
    );

    nor_id_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .preset    (accept),
        .cap_en    (sample_now && !poll_active),
        .step      (step_q),
        .rdata     (flash_rdata),
        .hold_word (hold_word),
        .ids       (ids)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            step_q  <= ST_RST_CMD;
            timed_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_STROBE;
                        step_q  <= ST_RST_CMD;
                        timed_q <= 1'b0;
                    end
                end
                PH_STROBE: phase_q <= PH_SAMPLE;
                PH_SAMPLE: begin
                    if (poll_active) begin
                        if (poll_match) begin
                            phase_q <= PH_DONE;
                        end else if (poll_last) begin
                            phase_q <= PH_DONE;
                            timed_q <= 1'b1;
                        end else begin
                            phase_q <= PH_STROBE;
                        end
                    end else begin
                        step_q  <= step_e'(step_q + 4'd1);
                        phase_q <= PH_STROBE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign flash_wr    = (phase_q == PH_STROBE) &&  op.is_wr;
    assign flash_rd    = (phase_q == PH_STROBE) && !op.is_wr;
    assign flash_addr  = ADDR_W'(op.offs);
    assign flash_wdata = DATA_W'(op.cmd);
    assign done        = (phase_q == PH_DONE);
    assign timed_out   = done && timed_q;
    assign id_vendor   = ids[0];
    assign id_dev1     = ids[1];
    assign id_dev2     = ids[2];
    assign id_dev3     = ids[3];

    // R7: the two strobes never coincide
    a_r7_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        !(flash_wr && flash_rd));
    // R7: a write strobe lasts exactly one clock
    a_r7_wr_single: assert property (@(posedge clk) disable iff (rst)
        flash_wr |=> !(flash_wr || flash_rd));
    // R7: a read strobe lasts exactly one clock
    a_r7_rd_single: assert property (@(posedge clk) disable iff (rst)
        flash_rd |=> !(flash_wr || flash_rd));
    // R8: read data is sampled the clock after the read strobe
    a_r8_sample_after_rd: assert property (@(posedge clk) disable iff (rst)
        sample_now |-> $past(flash_rd));
    // R9: done is a single-clock pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9: timeout only rides on done
    a_r9_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
        timed_out |-> done);
    // R2: an accepted start leads to the reset-command write
    a_r2_first_op: assert property (@(posedge clk) disable iff (rst)
        accept |=> (flash_wr && flash_wdata == DATA_W'(CMD_RESET)));
    // R11: a running sequence is not disturbed by start
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STROBE && start) |=> (phase_q == PH_SAMPLE));
endmodule

// File: tb/nor_id_probe_tb_top.sv
module nor_flash_model #(
    parameter int BYTE_MAP = 0,
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] vend,
    input  logic [DW-1:0] d1,
    input  logic [DW-1:0] d2,
    input  logic [DW-1:0] d3,
    input  logic [DW-1:0] arr0,
    input  int            exit_dly
);
    localparam logic [AW-1:0] UA = (BYTE_MAP != 0) ? AW'(12'hAAA) : AW'(12'h555);
    localparam logic [AW-1:0] UB = (BYTE_MAP != 0) ? AW'(12'h555) : AW'(12'h2AA);
    localparam int SH = (BYTE_MAP != 0) ? 1 : 0;

    logic id_mode;
    int ucnt, pend, n_ops, dual_cnt, back_cnt;
    logic prev_stb;
    logic          lg_wr   [128];
    logic [AW-1:0] lg_addr [128];
    logic [DW-1:0] lg_data [128];

    function automatic logic [DW-1:0] id_val(input logic [AW-1:0] a);
        if (a == AW'(0))          return vend;
        if (a == AW'(1 << SH))    return d1;
        if (a == AW'(14 << SH))   return d2;
        if (a == AW'(15 << SH))   return d3;
        return '0;
    endfunction

    always @(posedge clk) begin
        if (rst || clr) begin
            id_mode <= 1'b0; ucnt <= 0; pend <= 0; n_ops <= 0;
            rdata <= '0; dual_cnt <= 0; back_cnt <= 0; prev_stb <= 1'b0;
        end else begin
            prev_stb <= wr || rd;
            if (wr && rd) dual_cnt <= dual_cnt + 1;
            if ((wr || rd) && prev_stb) back_cnt <= back_cnt + 1;
            if (wr || rd) begin
                if (n_ops < 128) begin
                    lg_wr[n_ops] <= wr; lg_addr[n_ops] <= addr; lg_data[n_ops] <= wdata;
                end
                n_ops <= n_ops + 1;
            end
            if (wr) begin
                if (wdata[7:0] == 8'hF0) begin
                    if (id_mode) pend <= exit_dly;
                    id_mode <= 1'b0; ucnt <= 0;
                end else if (wdata[7:0] == 8'hAA && addr == UA) ucnt <= 1;
                else if (wdata[7:0] == 8'h55 && addr == UB && ucnt == 1) ucnt <= 2;
                else if (wdata[7:0] == 8'h90 && addr == UA && ucnt == 2) begin
                    id_mode <= 1'b1; ucnt <= 0;
                end else ucnt <= 0;
            end
            if (rd) begin
                if (id_mode) rdata <= id_val(addr);
                else if (pend > 0) begin rdata <= ~arr0; pend <= pend - 1; end
                else rdata <= (addr == '0) ? arr0 : DW'(addr * 3 + 1);
            end
        end
    end
endmodule

module nor_id_probe_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int PL = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic start_w = 1'b0, start_b = 1'b0, clr = 1'b0;
    logic [DW-1:0] vend, d1, d2, d3, arr0;
    int exit_dly = 0;

    logic done_w, to_w, wr_w, rd_w, done_b, to_b, wr_b, rd_b;
    logic [DW-1:0] iv_w, i1_w, i2_w, i3_w, wd_w, rdat_w;
    logic [DW-1:0] iv_b, i1_b, i2_b, i3_b, wd_b, rdat_b;
    logic [AW-1:0] ad_w, ad_b;

    int total = 0, bad = 0, cyc = 0, done_cnt = 0;

    nor_id_probe #(.ADDR_W(AW), .DATA_W(DW), .POLL_LIMIT(PL), .BYTE_MAP(0)) dut_i (
        .clk(clk), .rst(rst), .start(start_w), .done(done_w), .timed_out(to_w),
        .id_vendor(iv_w), .id_dev1(i1_w), .id_dev2(i2_w), .id_dev3(i3_w),
        .flash_addr(ad_w), .flash_wdata(wd_w), .flash_wr(wr_w), .flash_rd(rd_w),
        .flash_rdata(rdat_w));

    nor_id_probe #(.ADDR_W(AW), .DATA_W(DW), .POLL_LIMIT(PL), .BYTE_MAP(1)) dut_byte_i (
        .clk(clk), .rst(rst), .start(start_b), .done(done_b), .timed_out(to_b),
        .id_vendor(iv_b), .id_dev1(i1_b), .id_dev2(i2_b), .id_dev3(i3_b),
        .flash_addr(ad_b), .flash_wdata(wd_b), .flash_wr(wr_b), .flash_rd(rd_b),
        .flash_rdata(rdat_b));

    nor_flash_model #(.BYTE_MAP(0), .AW(AW), .DW(DW)) m_w (
        .clk(clk), .rst(rst), .clr(clr), .addr(ad_w), .wdata(wd_w), .wr(wr_w), .rd(rd_w),
        .rdata(rdat_w), .vend(vend), .d1(d1), .d2(d2), .d3(d3), .arr0(arr0), .exit_dly(exit_dly));

    nor_flash_model #(.BYTE_MAP(1), .AW(AW), .DW(DW)) m_b (
        .clk(clk), .rst(rst), .clr(clr), .addr(ad_b), .wdata(wd_b), .wr(wr_b), .rd(rd_b),
        .rdata(rdat_b), .vend(vend), .d1(d1), .d2(d2), .d3(d3), .arr0(arr0), .exit_dly(exit_dly));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst && (done_w || done_b)) done_cnt <= done_cnt + 1;
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            finish_up();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected op i: {is_wr, addr, wdata(for writes)}
    function automatic logic [AW-1:0] exp_addr(input int i, input bit bm);
        logic [AW-1:0] ua, ub;
        ua = bm ? 16'h0AAA : 16'h0555;
        ub = bm ? 16'h0555 : 16'h02AA;
        case (i)
            0, 2, 4: return ua;
            3:       return ub;
            6:       return bm ? 16'h0002 : 16'h0001;
            7:       return bm ? 16'h001C : 16'h000E;
            8:       return bm ? 16'h001E : 16'h000F;
            default: return '0;
        endcase
    endfunction

    function automatic logic exp_wr(input int i);
        return (i == 0 || i == 2 || i == 3 || i == 4 || i == 9);
    endfunction

    function automatic logic [DW-1:0] exp_cmd(input int i);
        case (i)
            0, 9: return 16'h00F0;
            2:    return 16'h00AA;
            3:    return 16'h0055;
            4:    return 16'h0090;
            default: return '0;
        endcase
    endfunction

    task automatic run_query(input bit bm, input int dly, input bit poke, input string tag);
        int polls, n_exp, nops, mism, first_bad, dc0, waited;
        logic got_to;
        logic [DW-1:0] gv, g1, g2, g3;
        polls = (dly < PL) ? dly + 1 : PL;
        n_exp = 10 + polls;
        vend = DW'($urandom); d1 = DW'($urandom); d2 = DW'($urandom); d3 = DW'($urandom);
        arr0 = DW'($urandom);
        exit_dly = dly;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        dc0 = done_cnt;
        if (bm) start_b = 1'b1; else start_w = 1'b1;
        @(negedge clk);
        start_b = 1'b0; start_w = 1'b0;
        // R10: all IDs are preset to ones right after an accepted start
        gv = bm ? iv_b : iv_w; g1 = bm ? i1_b : i1_w; g2 = bm ? i2_b : i2_w; g3 = bm ? i3_b : i3_w;
        chk({"R10 preset ", tag}, {gv, g1, g2, g3}, {64{1'b1}});
        waited = 0;
        while (!(bm ? done_b : done_w) && waited < 1000) begin
            if (poke && waited == 14) begin
                if (bm) start_b = 1'b1; else start_w = 1'b1;
            end else begin
                start_b = 1'b0; start_w = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start_b = 1'b0; start_w = 1'b0;
        got_to = bm ? to_b : to_w;
        gv = bm ? iv_b : iv_w; g1 = bm ? i1_b : i1_w; g2 = bm ? i2_b : i2_w; g3 = bm ? i3_b : i3_w;
        chk({"R9 done seen ", tag}, 64'(waited < 1000), 64'd1);
        // R4, R8: IDs land in order (a same-cycle sample would pick stale data)
        chk({"R4 R8 ids ", tag}, {gv, g1, g2, g3}, {vend, d1, d2, d3});
        // R6 / R9: timeout exactly when all poll reads missed
        chk({"R6 R9 timed_out ", tag}, 64'(got_to), 64'(dly >= PL));
        @(negedge clk);
        chk({"R9 done pulse low ", tag}, 64'(bm ? done_b : done_w), 64'd0);
        repeat (20) @(negedge clk);
        // R11: exactly one done per accepted start
        chk({"R11 single done ", tag}, 64'(done_cnt - dc0), 64'd1);
        nops = bm ? m_b.n_ops : m_w.n_ops;
        // R5, R6: number of poll reads follows the recorded-word match
        chk({"R5 R6 op count ", tag}, 64'(nops), 64'(n_exp));
        mism = 0; first_bad = -1;
        for (int i = 0; i < n_exp && i < 128; i++) begin
            logic w; logic [AW-1:0] a; logic [DW-1:0] d;
            w = bm ? m_b.lg_wr[i] : m_w.lg_wr[i];
            a = bm ? m_b.lg_addr[i] : m_w.lg_addr[i];
            d = bm ? m_b.lg_data[i] : m_w.lg_data[i];
            if (w !== exp_wr(i) || a !== exp_addr(i, bm) || (w && d !== exp_cmd(i))) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        end
        // R2, R3, R5: op order, addresses and command values
        chk({"R2 R3 R5 op sequence ", tag}, 64'(mism), 64'd0);
        if (mism != 0) $display("  first differing op index %0d", first_bad);
        // R7: single-clock strobes, never both, never back-to-back
        chk({"R7 strobes ", tag},
            64'((bm ? m_b.dual_cnt : m_w.dual_cnt) + (bm ? m_b.back_cnt : m_w.back_cnt)), 64'd0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240917);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 done/timeout", {62'd0, done_w, to_w}, 64'd0);
        chk("R1 strobes", {62'd0, wr_w, rd_w}, 64'd0);
        chk("R1 ids ones", {iv_w, i1_w, i2_w, i3_w}, {64{1'b1}});
        chk("R1 byte ids ones", {iv_b, i1_b, i2_b, i3_b}, {64{1'b1}});

        run_query(1'b0, 0,      1'b0, "word fast");
        run_query(1'b0, PL - 1, 1'b0, "word last poll");
        run_query(1'b0, PL,     1'b0, "word timeout");
        run_query(1'b1, 3,      1'b0, "byte map");
        run_query(1'b1, PL + 2, 1'b0, "byte timeout");
        run_query(1'b0, 6,      1'b1, "word busy start R11");
        run_query(1'b1, 6,      1'b1, "byte busy start R11");
        for (int k = 0; k < 10; k++) begin
            run_query(1'($urandom_range(0, 1)), int'($urandom_range(0, PL + 5)), 1'b0, "random");
        end
        finish_up();
    end
endmodule